// File: doc/BRIEF.md
# Four-Channel Trigger Aligner

This block takes one asynchronous trigger input and produces four output pulses from it. Each output waits for its own programmed number of clock cycles before it rises. Downstream devices with different firing latencies can then be made to act at the same instant. Every output is held high for a common programmed width, whatever the width of the incoming trigger.

A processor sets the four delays, the shared width and the per-channel enables through a small memory-mapped register port. The same port reads back a busy flag for each channel and a sticky overrun flag. The trigger is a plain level and the register port is a plain strobe interface. Writes take effect on the clock edge where `bus_wr` is high, and reads are combinational from `bus_addr`. No data flows through the block, so there is no back-pressure on either side.

Register map, with `bus_addr` counted in words:
- 0: enable mask, bit i for channel i.
- 1: pulse width.
- 2: status, with busy flags in bits [3:0] and overrun in bit 8. Writing 1 to bit 8 clears overrun.
- 4 to 7: delay of channels 0 to 3.

Top module: `trig_align`

## Requirements
- R1: After reset, all outputs are low, and the enable mask, width, delays, busy flags and overrun flag read as 0.
- R2: The trigger passes through two synchronizing flops. When a rising trigger is first sampled at clock edge P0, an enabled channel with delay D drives its output high in the cycle that starts at edge P(2+D).
- R3: An output stays high for W consecutive cycles, where W is the width register (bits [15:0] at address 1). A width of 0 gives one cycle.
- R4: Only a rising trigger edge starts a cycle. A trigger held high for many cycles produces exactly one pulse per enabled channel.
- R5: Each channel uses its own delay register (address 4+i), independently of the other channels.
- R6: A channel whose enable bit (address 0, bit i) is 0 keeps its output low and does not become busy.
- R7: A rising trigger edge that arrives while any channel is busy does not change any output. It sets overrun (address 2, bit 8), which stays set until a write to address 2 with bit 8 = 1.
- R8: Busy bit i (address 2, bit i) is 1 from the edge that starts channel i through the last cycle of its pulse, and is 0 otherwise.
- R9: The width and delay registers read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_in | input | 1 | External trigger, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| pulse_out | output | 4 | Aligned and stretched channel outputs |

## Verification
The main stimulus is a sweep of short triggers over every combination of four widths (including 0), four rotations of distinct per-channel delays (including 0), and three enable masks. From these runs the bench measures each channel's first high sample and its pulse length. These measurements separate an off-by-one in the delay path from one in the width path, show whether delays are swapped between channels, and show whether enable gating leaks. A trigger held high for many cycles shows whether the block starts on the level instead of the edge. A second rising edge during a long delay shows whether a busy channel restarts, or whether the overrun flag is lost or fails to clear.

// File: rtl/trig_align_pkg.sv
package trig_align_pkg;
  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_WAIT = 2'd1,
    CH_FIRE = 2'd2
  } ch_state_e;

  localparam int unsigned REG_ENABLE = 0;
  localparam int unsigned REG_WIDTH  = 1;
  localparam int unsigned REG_STATUS = 2;
  localparam int unsigned OVR_BIT    = 8;
endpackage

// File: rtl/trig_align_edge.sv
module trig_align_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= async_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;
endmodule

// File: rtl/trig_align_chan.sv
module trig_align_chan
  import trig_align_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] delay,
  input  logic [CW-1:0] width,
  output logic          fire,
  output logic          busy
);
  ch_state_e     state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] w_last;

  assign w_last = (width == '0) ? '0 : width - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= CH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        CH_IDLE: if (start) begin
          if (delay == '0) begin
            state <= CH_FIRE;
            cnt   <= w_last;
          end else begin
            state <= CH_WAIT;
            cnt   <= delay - 1'b1;
          end
        end
        CH_WAIT: if (cnt == '0) begin
          state <= CH_FIRE;
          cnt   <= w_last;
        end else begin
          cnt <= cnt - 1'b1;
        end
        CH_FIRE: if (cnt == '0) begin
          state <= CH_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: state <= CH_IDLE;
      endcase
    end
  end

  assign fire = (state == CH_FIRE);
  assign busy = (state != CH_IDLE);
endmodule

// File: rtl/trig_align_regs.sv
module trig_align_regs
  import trig_align_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16,
  localparam int CIW = $clog2(NCH),
  localparam int AW  = CIW + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic [AW-1:0]           addr,
  input  logic [CW-1:0]           wdata,
  input  logic [NCH-1:0]          busy,
  input  logic                    ovr_set,
  output logic [NCH-1:0]          en,
  output logic [CW-1:0]           width,
  output logic [NCH-1:0][CW-1:0]  delay,
  output logic [CW-1:0]           rdata
);
  logic ovr_q;
  logic is_dly;

  assign is_dly = addr[AW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= '0;
      width <= '0;
      ovr_q <= 1'b0;
    end else begin
      if (wr && !is_dly && addr[CIW-1:0] == CIW'(REG_ENABLE)) en <= wdata[NCH-1:0];
      if (wr && !is_dly && addr[CIW-1:0] == CIW'(REG_WIDTH))  width <= wdata;
      if (ovr_set) ovr_q <= 1'b1;
      else if (wr && !is_dly && addr[CIW-1:0] == CIW'(REG_STATUS) && wdata[OVR_BIT])
        ovr_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) delay[i] <= '0;
      else if (wr && is_dly && addr[CIW-1:0] == CIW'(i)) delay[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (is_dly) begin
      rdata = delay[addr[CIW-1:0]];
    end else begin
      if (addr[CIW-1:0] == CIW'(REG_ENABLE)) rdata[NCH-1:0] = en;
      if (addr[CIW-1:0] == CIW'(REG_WIDTH))  rdata = width;
      if (addr[CIW-1:0] == CIW'(REG_STATUS)) begin
        rdata[NCH-1:0] = busy;
        rdata[OVR_BIT] = ovr_q;
      end
    end
  end
endmodule

// File: rtl/trig_align.sv
module trig_align #(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   trig_in,
  input  logic                   bus_wr,
  input  logic [$clog2(NCH):0]   bus_addr,
  input  logic [CW-1:0]          bus_wdata,
  output logic [CW-1:0]          bus_rdata,
  output logic [NCH-1:0]         pulse_out
);
  logic                   trig_edge;
  logic                   any_busy;
  logic                   go;
  logic [NCH-1:0]         ctl_en;
  logic [CW-1:0]          ctl_width;
  logic [NCH-1:0][CW-1:0] ctl_delay;
  logic [NCH-1:0]         ch_busy;
  logic [NCH-1:0]         ch_fire;

  trig_align_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (trig_in),
    .rise     (trig_edge)
  );

  assign any_busy = |ch_busy;
  assign go       = trig_edge & ~any_busy;

  trig_align_regs #(.NCH(NCH), .CW(CW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .busy    (ch_busy),
    .ovr_set (trig_edge & any_busy),
    .en      (ctl_en),
    .width   (ctl_width),
    .delay   (ctl_delay),
    .rdata   (bus_rdata)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    trig_align_chan #(.CW(CW)) u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .start (go & ctl_en[i]),
      .delay (ctl_delay[i]),
      .width (ctl_width),
      .fire  (ch_fire[i]),
      .busy  (ch_busy[i])
    );
    assign pulse_out[i] = ch_fire[i] & ctl_en[i];
  end
endmodule

// File: rtl/trig_align_chk.sv
module trig_align_chk #(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr,
  input logic [$clog2(NCH):0] bus_addr,
  input logic [CW-1:0]        bus_wdata,
  input logic [CW-1:0]        bus_rdata,
  input logic [NCH-1:0]       pulse_out,
  input logic [NCH-1:0]       en,
  input logic [NCH-1:0]       busy,
  input logic [NCH-1:0]       fire,
  input logic                 edge_det
);
  logic ovr;
  logic clr_wr;
  assign ovr    = (bus_addr == 2) ? bus_rdata[8] : 1'b0;
  assign clr_wr = bus_wr && bus_addr == 2 && bus_wdata[8];

  a_r4_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
    edge_det |=> !edge_det);

  a_r7_busy_trigger_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_det && |busy) |=> $stable(fire));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    a_r6_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
      !en[i] |-> !pulse_out[i]);
    a_r8_out_busy: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_out[i] |-> busy[i]);
    a_r3_fire_before_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[i]) |-> $past(fire[i]));
  end

  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !clr_wr && bus_addr == 2) |=> (bus_addr != 2 || ovr));
endmodule

bind trig_align trig_align_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pulse_out (pulse_out),
  .en        (ctl_en),
  .busy      (ch_busy),
  .fire      (ch_fire),
  .edge_det  (trig_edge)
);

// File: tb/test_trig_align.sv
`timescale 1ns/1ps
module test_trig_align;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_in = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  pulse_out;

  int checks = 0;
  int failures = 0;
  int first_k [4];
  int high_n [4];
  logic [3:0] busy_at3;
  logic [3:0] busy_end;

  always #4 clk = ~clk;

  trig_align i_trig_align (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pulse_out(pulse_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // trigger raised now (at a negedge); sample index k counts later negedges
  task automatic run(input int hold, input int re_on, input int re_off, input int len);
    for (int c = 0; c < 4; c++) begin first_k[c] = -1; high_n[c] = 0; end
    bus_addr = 3'd2;
    trig_in = 1'b1;
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      if (k == hold) trig_in = 1'b0;
      if (k == re_on) trig_in = 1'b1;
      if (k == re_off) trig_in = 1'b0;
      for (int c = 0; c < 4; c++)
        if (pulse_out[c]) begin
          if (first_k[c] < 0) first_k[c] = k;
          high_n[c]++;
        end
      if (k == 3) busy_at3 = bus_rdata[3:0];
    end
    busy_end = bus_rdata[3:0];
  endtask

  initial begin
    logic [15:0] d;
    int dl [4];
    int we;
    logic [3:0] m;
    logic [3:0] masks [3];
    masks[0] = 4'hF; masks[1] = 4'b0101; masks[2] = 4'b0000;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(pulse_out == 4'b0, "R1 outputs", int'(pulse_out), 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check(d == 16'h0, "R1 register", int'(d), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R9 readback
    wr(3'd1, 16'hA5C3); rd(3'd1, d);
    check(d == 16'hA5C3, "R9 width", int'(d), 16'hA5C3);
    for (int c = 0; c < 4; c++) begin
      wr(3'(4 + c), 16'(16'h1111 * (c + 1)));
    end
    for (int c = 0; c < 4; c++) begin
      rd(3'(4 + c), d);
      check(d == 16'(16'h1111 * (c + 1)), "R9 delay", int'(d), 16'h1111 * (c + 1));
    end

    // sweep: R2 R3 R5 R6 R8
    for (int w = 0; w < 4; w++) begin
      int wv = (w == 3) ? 4 : w;
      we = (wv == 0) ? 1 : wv;
      wr(3'd1, 16'(wv));
      for (int s = 0; s < 4; s++) begin
        for (int c = 0; c < 4; c++) begin
          dl[c] = (c + s) % 4 + ((c == 3 - s) ? 2 : 0);
          wr(3'(4 + c), 16'(dl[c]));
        end
        for (int mi = 0; mi < 3; mi++) begin
          m = masks[mi];
          wr(3'd0, {12'h0, m});
          @(negedge clk);
          run(2, 0, 0, 20);
          for (int c = 0; c < 4; c++) begin
            if (m[c]) begin
              check(first_k[c] == 3 + dl[c], "R2 R5 delay", first_k[c], 3 + dl[c]);
              check(high_n[c] == we, "R3 width", high_n[c], we);
            end else begin
              check(high_n[c] == 0, "R6 disabled output", high_n[c], 0);
            end
          end
          check(busy_at3 == m, "R8 busy during", int'(busy_at3), int'(m));
          check(busy_end == 4'b0, "R8 idle after", int'(busy_end), 0);
        end
      end
    end

    // R4 long trigger
    wr(3'd0, 16'hF); wr(3'd1, 16'd1);
    for (int c = 0; c < 4; c++) wr(3'(4 + c), 16'd0);
    @(negedge clk);
    run(15, 0, 0, 25);
    for (int c = 0; c < 4; c++)
      check(high_n[c] == 1 && first_k[c] == 3, "R4 single pulse", high_n[c], 1);

    // R7 overrun
    rd(3'd2, d);
    check(d[8] == 1'b0, "R7 overrun clear before", int'(d[8]), 0);
    wr(3'd1, 16'd4);
    for (int c = 0; c < 4; c++) wr(3'(4 + c), 16'd6);
    @(negedge clk);
    run(2, 4, 6, 30);
    for (int c = 0; c < 4; c++) begin
      check(first_k[c] == 9, "R7 ignored retrigger start", first_k[c], 9);
      check(high_n[c] == 4, "R7 ignored retrigger width", high_n[c], 4);
    end
    rd(3'd2, d);
    check(d[8] == 1'b1, "R7 overrun set", int'(d[8]), 1);
    wr(3'd2, 16'h0000); rd(3'd2, d);
    check(d[8] == 1'b1, "R7 overrun sticky", int'(d[8]), 1);
    wr(3'd2, 16'h0100); rd(3'd2, d);
    check(d[8] == 1'b0, "R7 overrun cleared", int'(d[8]), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule